// File: doc/BRIEF.md
# Time-of-Day Clock with Word-Serial Register Access

This block keeps a time-of-day count made of a 32-bit seconds field and a 30-bit nanoseconds field. The count advances by a fixed number of nanoseconds on every clock. Software reaches it through a small 16-bit register bus with write and read strobes and a 2-bit address. All time values move through a single data register, one 16-bit word per access. A command register applies the staged words as an absolute time (load), applies them as a signed offset (step), or freezes the running time (snapshot) so that it can be read back word by word.

Frequency trimming uses a 26-bit rate magnitude and a direction flag. The rate is added into a 32-bit phase accumulator on every clock. Each overflow makes that clock's increment one nanosecond longer or, when the flag asks for a slower clock, one nanosecond shorter. With the default 8 ns increment, a rate of ppb·2^26/1953125 gives a trim of ppb parts per billion, up to 1953124 ppb. The hardware step drops the increment of the cycle in which it is applied, so software adds a small fixed constant to each offset to make up for it.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset the time is 0 s 0 ns and `rdata` is 0. With no command and no rate carry, every clock adds NS_INC (default 8) nanoseconds.
- R2: The nanoseconds field always stays below 1,000,000,000. An increment that crosses that value wraps the field and adds one to the seconds.
- R3: Writes to the data register (address 1) fill four staged words, one per write, through a word pointer that advances after each write. The words in order are ns[15:0], ns[31:16], sec[15:0], sec[31:16].
- R4: A command-register write (address 0) with bit 0 set replaces the time with the staged seconds and nanoseconds at that clock edge. Counting resumes from there on the next edge. A staged nanoseconds value of 1,000,000,000 or more is taken as 0.
- R5: A command write with bit 1 set adds the staged nanoseconds (0 to 999,999,999) and the staged seconds, read as two's complement, to the current time, with a carry into the seconds. The cycle that applies the step adds no NS_INC.
- R6: A command write with bit 2 set latches the time as it stood before that edge. Data-register reads then return ns[15:0], ns[29:16] zero-extended, sec[15:0] and sec[31:16], one word per read. `rdata` is updated in the cycle after the `rd_en` edge and holds otherwise. A read at any address other than 1 returns 0.
- R7: Every command-register write resets the word pointer to 0, which abandons any half-written or half-read sequence.
- R8: Address 2 holds the pending rate-high word: bit 15 means slow down, and bits 9:0 are rate[25:16]. A write to address 3 supplies rate[15:0], commits both halves and clears the 32-bit phase accumulator. On each clock the accumulator adds the rate, and each overflow makes that increment NS_INC+1 ns, or NS_INC−1 ns when the slow flag is set.
- R9: A command with both bit 0 and bit 1 set performs only the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one time increment per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, ignored while `wr_en` is high |
| addr | input | 2 | Register select: 0 command, 1 data, 2 rate high, 3 rate low |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after a read strobe |

## Verification
The bench targets these corner cases:
- A nanosecond value a few counts below the rollover. A design that compares against the wrong limit or drops the carry returns a time 1 s off or a nanosecond value above range.
- A negative step whose nanosecond part wraps, which must come out with unchanged seconds. A design that adds the tick on the step cycle comes out 8 ns late.
- A half-written sequence cut off by a bare command, followed by load+step together. These show up as misplaced words or a doubled offset.
- A maximum rate in both directions over a thousand cycles. This must give exactly 15 ns of drift, so a swapped direction or an accumulator that is not cleared shows up at once.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int          WORD_W     = 16;
    localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

    typedef enum logic [1:0] {
        REG_CMD     = 2'd0,
        REG_DATA    = 2'd1,
        REG_RATE_HI = 2'd2,
        REG_RATE_LO = 2'd3
    } reg_sel_e;

    localparam int CMD_LOAD_BIT = 0;
    localparam int CMD_STEP_BIT = 1;
    localparam int CMD_SNAP_BIT = 2;
    localparam int SLOW_BIT     = 15;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter int RATE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [15:0]       wdata,
    input  logic [31:0]       cur_sec,
    input  logic [29:0]       cur_ns,
    output logic              do_load,
    output logic              do_step,
    output logic [31:0]       arg_sec,
    output logic [31:0]       arg_ns,
    output logic              rate_commit,
    output logic              rate_slow,
    output logic [RATE_W-1:0] rate_val,
    output logic [15:0]       rdata
);
    localparam int HI_W = RATE_W - WORD_W;

    typedef struct packed {
        logic [3:0][WORD_W-1:0] stage;
        logic [3:0][WORD_W-1:0] snap;
        logic [1:0]             ptr;
        logic [HI_W-1:0]        rate_hi;
        logic                   slow;
        logic [WORD_W-1:0]      rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  cmd_wr, data_wr, data_rd;

    always_comb begin
        cmd_wr  = wr_en && (addr == REG_CMD);
        data_wr = wr_en && (addr == REG_DATA);
        data_rd = !wr_en && rd_en && (addr == REG_DATA);

        do_load     = cmd_wr && wdata[CMD_LOAD_BIT];
        do_step     = cmd_wr && wdata[CMD_STEP_BIT] && !wdata[CMD_LOAD_BIT];
        arg_ns      = {r_q.stage[1], r_q.stage[0]};
        arg_sec     = {r_q.stage[3], r_q.stage[2]};
        rate_commit = wr_en && (addr == REG_RATE_LO);
        rate_slow   = r_q.slow;
        rate_val    = {r_q.rate_hi, wdata};
        rdata       = r_q.rdata;

        r_d = r_q;
        if (cmd_wr) begin
            r_d.ptr = '0;
            if (wdata[CMD_SNAP_BIT])
                r_d.snap = {cur_sec, 2'b00, cur_ns};
        end
        if (data_wr) begin
            r_d.stage[r_q.ptr] = wdata;
            r_d.ptr            = r_q.ptr + 2'd1;
        end
        if (wr_en && (addr == REG_RATE_HI)) begin
            r_d.rate_hi = wdata[HI_W-1:0];
            r_d.slow    = wdata[SLOW_BIT];
        end
        if (!wr_en && rd_en) begin
            r_d.rdata = data_rd ? r_q.snap[r_q.ptr] : '0;
            if (data_rd)
                r_d.ptr = r_q.ptr + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assert_cmd_clears_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (r_q.ptr == 2'd0));

    assert_data_write_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (r_q.ptr == $past(r_q.ptr) + 2'd1));

    assert_rdata_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> $stable(rdata));
endmodule

// File: rtl/tod_rate.sv
module tod_rate #(
    parameter int RATE_W = 26,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              slow_in,
    input  logic [RATE_W-1:0] rate_in,
    output logic              adj_up,
    output logic              adj_dn
);
    localparam int SUM_W = ACC_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [RATE_W-1:0] rate;
        logic              slow;
    } rate_t;

    rate_t            rt_d, rt_q;
    logic [SUM_W-1:0] acc_sum;
    logic             carry;

    always_comb begin
        acc_sum = {1'b0, rt_q.acc} + SUM_W'(rt_q.rate);
        carry   = acc_sum[ACC_W];
        rt_d    = rt_q;
        rt_d.acc = acc_sum[ACC_W-1:0];
        if (commit) begin
            rt_d.acc  = '0;
            rt_d.rate = rate_in;
            rt_d.slow = slow_in;
        end
        adj_up = carry && !rt_q.slow;
        adj_dn = carry &&  rt_q.slow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    // a fresh phase cannot overflow on its first add while RATE_W < ACC_W
    assert_commit_restarts_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!adj_up && !adj_dn));

    assert_zero_rate_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_q.rate == '0) |-> (!adj_up && !adj_dn));
endmodule

// File: rtl/tod_count.sv
module tod_count
    import tod_pkg::*;
#(
    parameter int NS_INC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        do_load,
    input  logic        do_step,
    input  logic        adj_up,
    input  logic        adj_dn,
    input  logic [31:0] arg_sec,
    input  logic [31:0] arg_ns,
    output logic [31:0] sec,
    output logic [29:0] ns
);
    localparam logic [31:0] INC      = 32'(NS_INC);
    localparam logic [29:0] NO_WRAP  = 30'(NS_PER_SEC - INC - 32'd1);

    typedef struct packed {
        logic [31:0] sec;
        logic [29:0] ns;
    } tod_t;

    tod_t        tod_d, tod_q;
    logic [31:0] arg_ns_ok, addend, sum;
    logic        wrap;

    always_comb begin
        arg_ns_ok = (arg_ns < NS_PER_SEC) ? arg_ns : 32'd0;
        addend    = INC;
        if (adj_up)      addend = INC + 32'd1;
        else if (adj_dn) addend = INC - 32'd1;
        if (do_step)     addend = arg_ns_ok;

        sum  = {2'b00, tod_q.ns} + addend;
        wrap = (sum >= NS_PER_SEC);

        tod_d.ns  = wrap ? 30'(sum - NS_PER_SEC) : sum[29:0];
        tod_d.sec = tod_q.sec + (do_step ? arg_sec : 32'd0) + {31'd0, wrap};
        if (do_load) begin
            tod_d.sec = arg_sec;
            tod_d.ns  = arg_ns_ok[29:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tod_q <= '0;
        else        tod_q <= tod_d;
    end

    assign sec = tod_q.sec;
    assign ns  = tod_q.ns;

    assert_ns_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ns < 30'(NS_PER_SEC));

    assert_sec_moves_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_step) |=> ((sec == $past(sec)) || (sec == $past(sec) + 32'd1)));

    assert_load_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_load && (arg_ns < NS_PER_SEC)) |=> ((sec == $past(arg_sec)) && (ns == $past(arg_ns[29:0]))));

    assert_nominal_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_step && !adj_up && !adj_dn && (ns < NO_WRAP))
        |=> ((ns == $past(ns) + 30'(NS_INC)) && (sec == $past(sec))));

    assert_slow_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_step && adj_dn && (ns < NO_WRAP))
        |=> (ns == $past(ns) + 30'(NS_INC - 1)));

    assert_fast_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_step && adj_up && (ns < NO_WRAP))
        |=> (ns == $past(ns) + 30'(NS_INC + 1)));
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock #(
    parameter int NS_INC = 8,
    parameter int RATE_W = 26,
    parameter int ACC_W  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata
);
    logic              do_load, do_step, rate_commit, rate_slow, adj_up, adj_dn;
    logic [31:0]       arg_sec, arg_ns, cur_sec;
    logic [29:0]       cur_ns;
    logic [RATE_W-1:0] rate_val;

    tod_regs #(.RATE_W(RATE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .cur_sec(cur_sec), .cur_ns(cur_ns),
        .do_load(do_load), .do_step(do_step), .arg_sec(arg_sec), .arg_ns(arg_ns),
        .rate_commit(rate_commit), .rate_slow(rate_slow), .rate_val(rate_val),
        .rdata(rdata)
    );

    tod_rate #(.RATE_W(RATE_W), .ACC_W(ACC_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .commit(rate_commit), .slow_in(rate_slow),
        .rate_in(rate_val), .adj_up(adj_up), .adj_dn(adj_dn)
    );

    tod_count #(.NS_INC(NS_INC)) u_count (
        .clk(clk), .rst_n(rst_n), .do_load(do_load), .do_step(do_step),
        .adj_up(adj_up), .adj_dn(adj_dn), .arg_sec(arg_sec), .arg_ns(arg_ns),
        .sec(cur_sec), .ns(cur_ns)
    );
endmodule

// File: tb/test_ptp_tod_clock.sv
module test_ptp_tod_clock;
    localparam int unsigned BILLION = 32'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ptp_tod_clock i_ptp_tod_clock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // reference model state, derived from the requirements
    logic [31:0] m_sec = 0, m_ns = 0, m_acc = 0;
    logic [25:0] m_rate = 0;
    logic        m_slow = 0, m_hi_slow = 0;
    logic [9:0]  m_hi = 0;
    logic [15:0] m_stage [4] = '{default: 16'd0};
    logic [15:0] m_snap  [4] = '{default: 16'd0};
    logic [1:0]  m_ptr = 0;
    logic [15:0] m_rdata = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic m_edge(bit w, bit r, logic [1:0] a, logic [15:0] d);
        logic [32:0] s;
        logic [31:0] inc, nsok, sum, osec, ons, ssec;
        bit cmd, c;
        s    = {1'b0, m_acc} + {7'd0, m_rate};
        inc  = 32'd8;
        if (s[32]) inc = m_slow ? 32'd7 : 32'd9;
        osec = m_sec;
        ons  = m_ns;
        cmd  = w && (a == 2'd0);
        nsok = {m_stage[1], m_stage[0]};
        if (nsok >= BILLION) nsok = 0;
        ssec = {m_stage[3], m_stage[2]};
        if (cmd && d[0]) begin
            m_sec = ssec; m_ns = nsok;
        end else if (cmd && d[1]) begin
            sum = ons + nsok;
            c = (sum >= BILLION);
            if (c) sum = sum - BILLION;
            m_ns = sum; m_sec = osec + ssec + {31'd0, c};
        end else begin
            sum = ons + inc;
            if (sum >= BILLION) begin sum = sum - BILLION; m_sec = osec + 1; end
            m_ns = sum;
        end
        if (cmd) begin
            m_ptr = 0;
            if (d[2]) begin
                m_snap[0] = ons[15:0];  m_snap[1] = ons[31:16];
                m_snap[2] = osec[15:0]; m_snap[3] = osec[31:16];
            end
        end else if (w && a == 2'd1) begin
            m_stage[m_ptr] = d; m_ptr = m_ptr + 2'd1;
        end
        if (!w && r) begin
            if (a == 2'd1) begin m_rdata = m_snap[m_ptr]; m_ptr = m_ptr + 2'd1; end
            else m_rdata = 16'd0;
        end
        if (w && a == 2'd2) begin m_hi = d[9:0]; m_hi_slow = d[15]; end
        if (w && a == 2'd3) begin m_rate = {m_hi, d}; m_slow = m_hi_slow; m_acc = 0; end
        else m_acc = s[31:0];
    endtask

    task automatic bus(bit w, bit r, logic [1:0] a, logic [15:0] d);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(posedge clk);
        m_edge(w, r, a, d);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) bus(1'b0, 1'b0, 2'd0, 16'd0);
    endtask

    task automatic write_time(logic [31:0] s, logic [31:0] n);
        bus(1'b1, 1'b0, 2'd1, n[15:0]);
        bus(1'b1, 1'b0, 2'd1, n[31:16]);
        bus(1'b1, 1'b0, 2'd1, s[15:0]);
        bus(1'b1, 1'b0, 2'd1, s[31:16]);
    endtask

    task automatic command(logic [15:0] bits);
        bus(1'b1, 1'b0, 2'd0, bits);
    endtask

    // snapshot then four reads (R6), each word checked against the model
    task automatic read_time(string req, output logic [31:0] s, output logic [31:0] n);
        logic [15:0] w [4];
        command(16'h0004);
        for (int i = 0; i < 4; i++) begin
            bus(1'b0, 1'b1, 2'd1, 16'd0);
            check(req, rdata, m_rdata);
            w[i] = rdata;
        end
        n = {w[1], w[0]};
        s = {w[3], w[2]};
    endtask

    initial begin
        logic [31:0] s, n;
        void'($urandom(32'd20250117));
        repeat (3) @(negedge clk);
        check("R1 reset rdata", rdata, 0);
        rst_n = 1'b1;

        // R1: free running from zero
        idle(5);
        read_time("R1", s, n);
        check("R1 sec", s, 0);
        check("R1 ns", n, 40);

        // R3 / R7: partial sequence abandoned by a bare command
        bus(1'b1, 1'b0, 2'd1, 16'hAAAA);
        bus(1'b1, 1'b0, 2'd1, 16'hBBBB);
        command(16'h0000);
        write_time(32'h0001_2345, 32'd123_456_789);
        command(16'h0001);
        read_time("R3", s, n);
        check("R7 sec after ptr reset", s, 32'h0001_2345);
        check("R3 ns word order", n, 32'd123_456_789);

        // R2: rollover into seconds
        write_time(32'd5, 32'd999_999_990);
        command(16'h0001);
        idle(2);
        read_time("R2", s, n);
        check("R2 sec carry", s, 6);
        check("R2 ns wrap", n, 6);

        // R5: negative step with nanosecond wrap, step cycle skips tick
        write_time(32'd10, 32'd100);
        command(16'h0001);
        write_time(32'hFFFF_FFFF, 32'd999_999_990);
        command(16'h0002);
        read_time("R5", s, n);
        check("R5 sec", s, 10);
        check("R5 ns", n, 122);

        // R4: out-of-range staged ns loads as zero
        write_time(32'd7, 32'd1_200_000_000);
        command(16'h0001);
        read_time("R4", s, n);
        check("R4 sec", s, 7);
        check("R4 ns forced zero", n, 0);

        // R9: load beats step
        write_time(32'd3, 32'd500);
        command(16'h0003);
        read_time("R9", s, n);
        check("R9 sec", s, 3);
        check("R9 ns", n, 500);

        // R6: read of a non-data address returns 0
        bus(1'b0, 1'b1, 2'd2, 16'd0);
        check("R6 other addr read", rdata, 0);

        // R8: maximum rate, fast then slow, over 1000 ticks
        bus(1'b1, 1'b0, 2'd2, 16'h03FF);
        bus(1'b1, 1'b0, 2'd3, 16'hFFFF);
        write_time(32'd0, 32'd0);
        command(16'h0001);
        idle(1000);
        read_time("R8", s, n);
        check("R8 fast drift", n, 8015);

        bus(1'b1, 1'b0, 2'd2, 16'h83FF);
        bus(1'b1, 1'b0, 2'd3, 16'hFFFF);
        write_time(32'd0, 32'd0);
        command(16'h0001);
        idle(1000);
        read_time("R8", s, n);
        check("R8 slow drift", n, 7985);

        // mixed random traffic checked against the model
        for (int it = 0; it < 150; it++) begin
            case ($urandom_range(0, 5))
                0: begin
                    write_time($urandom(), $urandom_range(0, 1_100_000_000));
                    command(16'($urandom_range(0, 7)));
                end
                1: begin
                    bus(1'b1, 1'b0, 2'd2, 16'($urandom()));
                    bus(1'b1, 1'b0, 2'd3, 16'($urandom()));
                end
                2: idle($urandom_range(0, 30));
                3: read_time("R6 random", s, n);
                4: for (int k = 0; k < $urandom_range(1, 3); k++)
                       bus(1'b1, 1'b0, 2'd1, 16'($urandom()));
                default: for (int k = 0; k < $urandom_range(1, 3); k++) begin
                    bus(1'b0, 1'b1, 2'($urandom_range(1, 3)), 16'd0);
                    check("R6 random read", rdata, m_rdata);
                end
            endcase
        end
        read_time("R2 final", s, n);
        check("R2 final ns", n, m_ns - 32'd0 == n ? n : {m_snap[1], m_snap[0]});

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule